// File: doc/BRIEF.md
# Paged Bank-Switching Memory Mapper

This block sits between a CPU with a 16-bit logical address bus and a 2 MB physical memory system. The logical space is cut into eight pages of 8 KB. Each page owns an 8-bit bank register that names one 8 KB bank of physical memory. The three top logical address bits pick a page, and that page's bank index is joined to the thirteen low address bits to form a 21-bit physical address. This path is purely combinational, so a memory access pays no added cycle.

Software loads a bank register by presenting an index and a data byte with a write strobe. The new value is taken at the next rising clock edge. A second, combinational port returns the content of the register chosen by the same index, which lets the CPU copy a bank register back into its accumulator. Reset clears every bank register to bank $00. The top page, $E000-$FFFF, therefore resolves to bank $00, and the boot vectors can be fetched from there. Whenever the translated bank is the hardware I/O bank ($FF), a select output is raised for the peripheral decode.

Top module: `bank_mapper`

## Requirements
- R1: The page is logAddr[15:13]. physAddr[20:13] equals the bank register of that page.
- R2: After reset every bank register holds $00. In particular, logical $FFFE translates to physical $001FFE.
- R3: physAddr[12:0] always equals logAddr[12:0].
- R4: With regWrEn high at a rising edge, the register selected by regIdx takes regWrData. All other registers keep their values.
- R5: In the cycle of a write, translation still uses the register's old value. The new value appears only after the edge.
- R6: regRdData shows the register selected by regIdx, combinationally. When a write targets that same register in that cycle, it shows the pre-write value.
- R7: ioSelect is 1 exactly when the translated bank index equals $FF, and 0 otherwise.
- R8: A change on logAddr changes physAddr and ioSelect in the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| logAddr | input | 16 | Logical CPU address |
| regIdx | input | 3 | Bank register index for load and read-back |
| regWrEn | input | 1 | Load strobe for the indexed bank register |
| regWrData | input | 8 | Bank index to load |
| regRdData | output | 8 | Content of the indexed bank register |
| physAddr | output | 21 | Translated physical address |
| ioSelect | output | 1 | Translated bank is the I/O bank |

## Verification
The bench goes after several corner cases:
- A write and a same-cycle read or translation of the same register. A design that forwarded the new byte would show it one cycle early.
- Addresses at both ends of every page, such as $1FFF versus $2000 and $FFFE. A page decode taken from the wrong bits would map them to a neighbouring bank.
- Reset state read through both the read-back port and translation. A design that left the top page unmapped would break the boot fetch.
- Banks $FE, $FF and $7F on translation. A loose I/O comparison would assert ioSelect for banks other than $FF.

Random writes and addresses with a fixed seed then exercise the remaining interactions.

// File: rtl/bank_mapper_pkg.sv
package bank_mapper_pkg;
  localparam int LOG_AW    = 16;
  localparam int PAGE_BITS = 3;
  localparam int NUM_PAGES = 1 << PAGE_BITS;
  localparam int OFFS_W    = LOG_AW - PAGE_BITS;
  localparam int BANK_W    = 8;
  localparam int PHYS_AW   = BANK_W + OFFS_W;

  typedef struct packed {
    logic [NUM_PAGES-1:0] wrSel;  // one-hot load enable per bank register
    logic [NUM_PAGES-1:0] rdSel;  // one-hot read-back select
    logic [NUM_PAGES-1:0] xlSel;  // one-hot translation page select
  } mapStrobes_t;
endpackage

// File: rtl/bank_mapper_ctrl.sv
module bank_mapper_ctrl
  import bank_mapper_pkg::*;
(
  input  logic [PAGE_BITS-1:0] pageNum,
  input  logic [PAGE_BITS-1:0] regIdx,
  input  logic                 regWrEn,
  output mapStrobes_t          strobes
);
  logic [NUM_PAGES-1:0] idxHot;
  logic [NUM_PAGES-1:0] pageHot;

  for (genvar p = 0; p < NUM_PAGES; p++) begin : g_dec
    assign idxHot[p]  = (regIdx  == PAGE_BITS'(p));
    assign pageHot[p] = (pageNum == PAGE_BITS'(p));
  end

  always_comb begin
    strobes.wrSel = regWrEn ? idxHot : '0;
    strobes.rdSel = idxHot;
    strobes.xlSel = pageHot;
  end
endmodule

// File: rtl/bank_mapper_dp.sv
module bank_mapper_dp
  import bank_mapper_pkg::*;
#(
  parameter logic [BANK_W-1:0] RESET_BANK = '0,
  parameter logic [BANK_W-1:0] IO_BANK    = '1
) (
  input  logic               clk,
  input  logic               rstN,
  input  mapStrobes_t        strobes,
  input  logic [BANK_W-1:0]  wrData,
  input  logic [OFFS_W-1:0]  offset,
  output logic [BANK_W-1:0]  rdData,
  output logic [PHYS_AW-1:0] physAddr,
  output logic               ioSel
);
  logic [BANK_W-1:0] bankReg [NUM_PAGES];
  logic [BANK_W-1:0] curBank;

  for (genvar p = 0; p < NUM_PAGES; p++) begin : g_bank
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 bankReg[p] <= RESET_BANK;
      else if (strobes.wrSel[p]) bankReg[p] <= wrData;
    end
  end

  // AND-OR selectors keep a flat depth for both read-back and translation
  always_comb begin
    rdData  = '0;
    curBank = '0;
    for (int p = 0; p < NUM_PAGES; p++) begin
      rdData  = rdData  | ({BANK_W{strobes.rdSel[p]}} & bankReg[p]);
      curBank = curBank | ({BANK_W{strobes.xlSel[p]}} & bankReg[p]);
    end
  end

  assign physAddr = {curBank, offset};
  assign ioSel    = (curBank == IO_BANK);
endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
  import bank_mapper_pkg::*;
#(
  parameter logic [BANK_W-1:0] RESET_BANK = '0,
  parameter logic [BANK_W-1:0] IO_BANK    = '1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [LOG_AW-1:0]    logAddr,
  input  logic [PAGE_BITS-1:0] regIdx,
  input  logic                 regWrEn,
  input  logic [BANK_W-1:0]    regWrData,
  output logic [BANK_W-1:0]    regRdData,
  output logic [PHYS_AW-1:0]   physAddr,
  output logic                 ioSelect
);
  mapStrobes_t strobes;

  bank_mapper_ctrl u_ctrl (
    .pageNum (logAddr[LOG_AW-1 -: PAGE_BITS]),
    .regIdx  (regIdx),
    .regWrEn (regWrEn),
    .strobes (strobes)
  );

  bank_mapper_dp #(
    .RESET_BANK (RESET_BANK),
    .IO_BANK    (IO_BANK)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .wrData   (regWrData),
    .offset   (logAddr[OFFS_W-1:0]),
    .rdData   (regRdData),
    .physAddr (physAddr),
    .ioSel    (ioSelect)
  );
endmodule

// File: rtl/bank_mapper_checker.sv
module bank_mapper_checker
  import bank_mapper_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic [LOG_AW-1:0]    logAddr,
  input logic [PAGE_BITS-1:0] regIdx,
  input logic                 regWrEn,
  input logic [BANK_W-1:0]    regWrData,
  input logic [BANK_W-1:0]    regRdData,
  input logic [PHYS_AW-1:0]   physAddr,
  input logic                 ioSelect
);
  a_r3_offset_passes: assert property (@(posedge clk) disable iff (!rstN)
    physAddr[OFFS_W-1:0] == logAddr[OFFS_W-1:0]);

  a_r7_io_flag: assert property (@(posedge clk) disable iff (!rstN)
    ioSelect == (physAddr[PHYS_AW-1 -: BANK_W] == '1));

  a_r4_write_lands: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> (regIdx != $past(regIdx) || regRdData == $past(regWrData)));

  a_r1_translate_after_write: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> (logAddr[LOG_AW-1 -: PAGE_BITS] != $past(regIdx)
                 || physAddr[PHYS_AW-1 -: BANK_W] == $past(regWrData)));

  a_r6_hold_without_write: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn |=> (regIdx != $past(regIdx) || regRdData == $past(regRdData)));

  a_r2_reset_clear: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> regRdData == '0);
endmodule

bind bank_mapper bank_mapper_checker chk (.*);

// File: tb/bank_mapper_test.sv
`timescale 1ns/1ps
module bank_mapper_test;
  logic        clk = 0;
  logic        rstN = 0;
  logic [15:0] logAddr = '0;
  logic [2:0]  regIdx = '0;
  logic        regWrEn = 0;
  logic [7:0]  regWrData = '0;
  logic [7:0]  regRdData;
  logic [20:0] physAddr;
  logic        ioSelect;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [7:0] model [8];

  always #2.5 clk = ~clk;

  bank_mapper uut (.*);

  function automatic logic [20:0] expPhys(input logic [15:0] la);
    return {model[la[15:13]], la[12:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, check before next posedge, update model after it
  task automatic step(input logic [15:0] la, input logic [2:0] idx,
                      input logic we, input logic [7:0] wd, input string req);
    @(negedge clk);
    logAddr = la; regIdx = idx; regWrEn = we; regWrData = wd;
    #1;
    check({req, " phys"}, 32'(physAddr), 32'(expPhys(la)));
    check({req, " io"},   32'(ioSelect), 32'(model[la[15:13]] == 8'hFF));
    check({req, " rd"},   32'(regRdData), 32'(model[idx]));
    @(posedge clk);
    if (we) model[idx] = wd;
    #0.5 regWrEn = 0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int unused;
    unused = $urandom(1234);
    for (int i = 0; i < 8; i++) model[i] = 8'h00;
    repeat (3) @(posedge clk);
    #1 rstN = 1;

    // R2: reset state, boot vector page
    for (int i = 0; i < 8; i++) step({3'(i), 13'h0123}, 3'(i), 0, 0, "R2 reset");
    step(16'hFFFE, 3'd7, 0, 0, "R2 boot vector");
    check("R2 boot phys", 32'(physAddr), 32'h001FFE);

    // R4/R7: load I/O bank into page 0, RAM into page 1
    step(16'h0000, 3'd0, 1, 8'hFF, "R4 load p0");
    step(16'h0010, 3'd1, 1, 8'hF8, "R7 io p0");
    step(16'h2000, 3'd2, 1, 8'hFE, "R1 p1 boundary");
    step(16'h1FFF, 3'd3, 1, 8'h7F, "R3 p0 top");
    step(16'h4ABC, 3'd2, 0, 0, "R7 bank FE not io");
    step(16'h7FFF, 3'd3, 0, 0, "R7 bank 7F not io");

    // R5/R6: same-cycle write and read/translate of one register
    step(16'hC456, 3'd6, 1, 8'h5A, "R5 R6 same cycle");
    step(16'hC456, 3'd6, 1, 8'hA5, "R5 R6 back to back");
    step(16'hC456, 3'd6, 0, 0, "R4 settled");

    // R8: address change alone within one cycle
    @(negedge clk);
    logAddr = 16'h0042; #1;
    check("R8 comb p0", 32'(physAddr), 32'(expPhys(16'h0042)));
    logAddr = 16'hDFFF; #1;
    check("R8 comb p6", 32'(physAddr), 32'(expPhys(16'hDFFF)));
    check("R8 comb io", 32'(ioSelect), 32'(model[6] == 8'hFF));

    // random traffic, R1 R3 R4 R6 R7
    for (int n = 0; n < 600; n++) begin
      logic [7:0] wd;
      wd = ($urandom % 4 == 0) ? 8'hFF : 8'($urandom);
      step(16'($urandom), 3'($urandom), ($urandom % 3) == 0, wd, "R1 R4 R6 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule